// File: doc/BRIEF.md
# Burst Bus Transfer Controller

This block is the central engine of a single-clock shared bus. Several masters each own one request slot. A master loads its slot with a direction, a start address, a word count and an optional lock wish. The engine then serves the slot one 32-bit word per bus cycle until the whole burst is done. Addresses are byte addresses and words are 4 bytes wide. A slot moves through four status codes: queued, in service, finished cleanly, and finished with a failure. A one-cycle done pulse marks the end of each request.

The choice between competing slots is made outside the block. When no access is in flight, the engine offers every queued or in-service slot to an external arbiter and accepts its pick. It checks the picked address for word alignment and decodes it against a set of inclusive slave ranges. It then drives one slave access and acts on the slave's reply.

A burst gives up the bus after every word, so other masters can slip in between its words. A slave that answers "wait" keeps the same access on the bus, with no new arbitration, until it answers "ok" or "error". The engine also keeps a small lock field per slot, for the arbiter's use, and relaxes those fields whenever the bus ends a cycle with nothing in flight.

Top module: `burst_xfer_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the block is idle:
  - every slot status reads OK (code 2);
  - every lock field reads NONE (code 0);
  - no slave is selected and no done or issue-error pulse is high.
- R2: A legal issue is written at a clock edge and the slot reads QUEUED (code 0) in the following cycle. The issue carries a word count minus one, `C`; the burst covers addresses A, A+4, …, up to an end address of A + 4·C.
- R3: An access whose address has bit 1 or bit 0 set selects no slave. It ends the request with status ERROR (code 3) and a done pulse.
- R4: An address that lies in no slave's inclusive range selects no slave. It ends the request with ERROR and a done pulse.
- R5: An aligned address selects exactly one slave, the lowest-numbered one whose inclusive range holds it.
  - The default map places slave 0 at 0x0000–0x007F and slave 1 at 0x0080–0x00FF.
  - A select bit is high only during the cycle of the access.
- R6: A slave reply of OK (code 2) moves the slot address up by 4.
  - If the new address is past the end address, the status becomes OK and a done pulse follows the edge.
  - Otherwise the status reads WAIT (code 1) and the next word follows.
  - A zero-wait slave thus gives one word per cycle.
- R7: After each completed word of an unfinished burst, the engine goes back to arbitration. A higher-priority request can take the next cycle. An interrupted burst still ends with OK.
- R8: A slave reply of WAIT (any code other than 2 or 3) keeps the same slot, address and slave on the bus in the next cycle, and nothing is offered to the arbiter.
- R9: A slave reply of ERROR (code 3) ends the request with ERROR and a done pulse.
- R10: While no access is held, exactly the slots in QUEUED or WAIT status are offered to the arbiter. A valid pick of an offered slot starts its access in the same cycle, and the slot's status reads WAIT or a final code afterwards.
- R11: Lock fields use the codes NONE=0, HELD=1 and GRANTED=2.
  - An issue with the lock wish sets HELD, or GRANTED if the field was HELD.
  - A pick with the arbiter's lock flag turns a non-NONE field into GRANTED.
  - At the end of any cycle that leaves no access held, GRANTED becomes HELD and every other field becomes NONE.
  - A locked issue to a slot takes precedence over that slot's clearing in the same cycle.
- R12: Issuing to a slot whose status is QUEUED or WAIT is illegal. It raises that slot's issue-error pulse in the next cycle and leaves the slot's request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld | input | NM | Per-master issue strobe |
| iss_write | input | NM | Per-master direction, 1 = write |
| iss_lock | input | NM | Per-master lock wish |
| iss_addr | input | NM*AW | Per-master start byte address |
| iss_cnt | input | NM*CW | Per-master word count minus one |
| iss_err | output | NM | Per-master illegal-issue pulse |
| xfer_stat | output | 2*NM | Per-master status code |
| xfer_done | output | NM | Per-master completion pulse |
| arb_offer | output | NM | Slots offered for arbitration |
| arb_lock | output | 2*NM | Per-master lock field for the arbiter |
| arb_pick_vld | input | 1 | Arbiter has a pick |
| arb_pick_idx | input | IW | Index of the picked slot |
| arb_pick_lock | input | 1 | Arbiter asks to grant the pick's lock |
| slv_sel | output | NS | One-hot slave select |
| slv_write | output | 1 | Direction of the current access |
| slv_addr | output | AW | Byte address of the current access |
| slv_owner | output | IW | Master index owning the current access |
| slv_resp | input | 2*NS | Per-slave reply code, same cycle |

## Verification
Two of the block's functions can land on the same lock field at one clock edge. The first is the idle-cycle lock relaxation. The second is a fresh locked issue from a master whose request has just completed.

The bench provokes this clash directly. It issues a new locked request from a master in the very cycle its done pulse is seen. The bus is idle in that cycle, so relaxation would otherwise turn the field from HELD to NONE.

The issue must win. The field must read GRANTED in the next cycle, then fall back to HELD after that request is served, and to NONE one idle cycle later.

A second overlap is also exercised. A queued request enters between two words of another master's burst, and the interrupted burst must still finish cleanly.

// File: rtl/bxc_pkg.sv
// Shared types of the burst bus transfer controller.
// Assumes two-bit status and lock codes that the ports carry unencoded.
package bxc_pkg;

    typedef enum logic [1:0] {
        ST_QUEUED = 2'd0,
        ST_BUSY   = 2'd1,
        ST_OK     = 2'd2,
        ST_FAIL   = 2'd3
    } xfer_st_t;

    typedef enum logic [1:0] {
        LK_NONE  = 2'd0,
        LK_HELD  = 2'd1,
        LK_GRANT = 2'd2
    } lock_st_t;

    // True for a status that allows a new issue.
    function automatic logic st_final(input logic [1:0] s);
        return (s == ST_OK) || (s == ST_FAIL);
    endfunction

endpackage

// File: rtl/bxc_slot_bank.sv
// Request slot storage, one slot per master.
// Holds direction, current address, end address, status and lock field.
// Assumes the engine never updates a slot that is being issued to. The
// engine only touches QUEUED or WAIT slots, and those refuse issues.
module bxc_slot_bank
    import bxc_pkg::*;
#(
    parameter int NM = 3,
    parameter int AW = 16,
    parameter int CW = 4,
    parameter int IW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NM-1:0]     iss_vld,
    input  logic [NM-1:0]     iss_write,
    input  logic [NM-1:0]     iss_lock,
    input  logic [NM*AW-1:0]  iss_addr,
    input  logic [NM*CW-1:0]  iss_cnt,
    input  logic              upd_vld,
    input  logic [IW-1:0]     upd_idx,
    input  logic [1:0]        upd_stat,
    input  logic              upd_step,
    input  logic              grant_vld,
    input  logic [IW-1:0]     grant_idx,
    input  logic              clr_locks,
    output logic [NM*2-1:0]   stat_flat,
    output logic [NM*2-1:0]   lock_flat,
    output logic [NM*AW-1:0]  addr_flat,
    output logic [NM*(AW+1)-1:0] end_flat,
    output logic [NM-1:0]     wr_vec,
    output logic [NM-1:0]     iss_err
);

    for (genvar g = 0; g < NM; g++) begin : g_slot
        logic [1:0]    stat_q;
        logic [1:0]    lock_q;
        logic [1:0]    lock_nx;
        logic [AW-1:0] addr_q;
        logic [AW:0]   end_q;
        logic          wr_q;
        logic          err_q;
        logic          take;
        logic          mine;

        // Purpose: decide whether this cycle's issue is legal and whether the engine targets this slot.
        always_comb begin
            take = iss_vld[g] && st_final(stat_q);
            mine = upd_vld && (upd_idx == IW'(g));
        end

        // Purpose: next lock value; a locked issue overrides grant and idle relaxation.
        always_comb begin
            lock_nx = lock_q;
            if (take && iss_lock[g]) begin
                lock_nx = (lock_q == LK_HELD) ? LK_GRANT : LK_HELD;
            end else begin
                if (grant_vld && (grant_idx == IW'(g)) && (lock_q != LK_NONE)) begin
                    lock_nx = LK_GRANT;
                end
                if (clr_locks) begin
                    lock_nx = (lock_nx == LK_GRANT) ? LK_HELD : LK_NONE;
                end
            end
        end

        // Purpose: register the slot fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q <= ST_OK;
                lock_q <= LK_NONE;
                addr_q <= '0;
                end_q  <= '0;
                wr_q   <= 1'b0;
                err_q  <= 1'b0;
            end else begin
                err_q  <= iss_vld[g] && !take;
                lock_q <= lock_nx;
                if (take) begin
                    stat_q <= ST_QUEUED;
                    wr_q   <= iss_write[g];
                    addr_q <= iss_addr[g*AW +: AW];
                    end_q  <= {1'b0, iss_addr[g*AW +: AW]}
                              + (AW+1)'({iss_cnt[g*CW +: CW], 2'b00});
                end else if (mine) begin
                    stat_q <= upd_stat;
                    if (upd_step) begin
                        addr_q <= addr_q + AW'(4);
                    end
                end
            end
        end

        assign stat_flat[g*2 +: 2]         = stat_q;
        assign lock_flat[g*2 +: 2]         = lock_q;
        assign addr_flat[g*AW +: AW]       = addr_q;
        assign end_flat[g*(AW+1) +: AW+1]  = end_q;
        assign wr_vec[g]                   = wr_q;
        assign iss_err[g]                  = err_q;
    end

endmodule

// File: rtl/bxc_range_decode.sv
// Address range decoder.
// Compares one byte address against NS inclusive ranges and returns a
// one-hot hit on the lowest-numbered matching range.
// Assumes the ranges come as packed parameter vectors, slave k in slice k.
module bxc_range_decode #(
    parameter int NS = 2,
    parameter int AW = 16,
    parameter logic [NS*AW-1:0] LO = '0,
    parameter logic [NS*AW-1:0] HI = '0
) (
    input  logic [AW-1:0] addr,
    output logic [NS-1:0] hit,
    output logic          any
);

    logic [NS-1:0] in_rng;

    for (genvar k = 0; k < NS; k++) begin : g_rng
        assign in_rng[k] = (addr >= LO[k*AW +: AW]) && (addr <= HI[k*AW +: AW]);
    end

    // Purpose: keep only the first matching range.
    always_comb begin
        hit = '0;
        for (int k = NS - 1; k >= 0; k--) begin
            if (in_rng[k]) begin
                hit = '0;
                hit[k] = 1'b1;
            end
        end
    end

    assign any = |in_rng;

endmodule

// File: rtl/bxc_engine.sv
// Bus engine: holds the current request, consults the arbiter when idle,
// drives one slave access per cycle and turns the reply into slot updates.
// Assumes the slave reply arrives in the same cycle as the select. The
// arbiter pick is combinational on arb_offer.
module bxc_engine
    import bxc_pkg::*;
#(
    parameter int NM = 3,
    parameter int NS = 2,
    parameter int AW = 16,
    parameter int IW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NM*2-1:0]       stat_flat,
    input  logic [NM*AW-1:0]      addr_flat,
    input  logic [NM*(AW+1)-1:0]  end_flat,
    input  logic [NM-1:0]         wr_vec,
    input  logic                  arb_pick_vld,
    input  logic [IW-1:0]         arb_pick_idx,
    input  logic                  arb_pick_lock,
    input  logic [NS-1:0]         dec_hit,
    input  logic                  dec_any,
    input  logic [NS*2-1:0]       slv_resp,
    output logic [NM-1:0]         arb_offer,
    output logic [AW-1:0]         act_addr,
    output logic [NS-1:0]         slv_sel,
    output logic                  slv_write,
    output logic [IW-1:0]         slv_owner,
    output logic                  upd_vld,
    output logic [IW-1:0]         upd_idx,
    output logic [1:0]            upd_stat,
    output logic                  upd_step,
    output logic                  grant_vld,
    output logic [IW-1:0]         grant_idx,
    output logic                  clr_locks,
    output logic [NM-1:0]         done
);

    logic [1:0]    st   [NM];
    logic [AW-1:0] ad   [NM];
    logic [AW:0]   en   [NM];

    for (genvar g = 0; g < NM; g++) begin : g_unpack
        assign st[g] = stat_flat[g*2 +: 2];
        assign ad[g] = addr_flat[g*AW +: AW];
        assign en[g] = end_flat[g*(AW+1) +: AW+1];
    end

    logic          cur_vld;
    logic [IW-1:0] cur_idx;
    logic [NM-1:0] done_q;
    logic          pick_ok;
    logic          act_vld;
    logic [IW-1:0] act_idx;
    logic [AW:0]   act_end;
    logic          go;
    logic [1:0]    sel_resp;
    logic [AW:0]   nxt_addr;
    logic          keep;
    logic          fin;

    // Purpose: offer queued and in-service slots only while nothing is held.
    always_comb begin
        for (int i = 0; i < NM; i++) begin
            arb_offer[i] = !cur_vld && ((st[i] == ST_QUEUED) || (st[i] == ST_BUSY));
        end
    end

    // Purpose: pick the slot served this cycle, either held or freshly arbitrated.
    always_comb begin
        pick_ok = 1'b0;
        if (arb_pick_vld && (int'(arb_pick_idx) < NM)) begin
            pick_ok = arb_offer[arb_pick_idx];
        end
        act_vld  = cur_vld || pick_ok;
        act_idx  = cur_vld ? cur_idx : arb_pick_idx;
        act_addr = '0;
        act_end  = '0;
        slv_write = 1'b0;
        if (int'(act_idx) < NM) begin
            act_addr  = ad[act_idx];
            act_end   = en[act_idx];
            slv_write = wr_vec[act_idx];
        end
        go       = act_vld && (act_addr[1:0] == 2'b00) && dec_any;
        slv_sel  = go ? dec_hit : '0;
        nxt_addr = {1'b0, act_addr} + (AW+1)'(4);
    end

    // Purpose: merge the reply of the selected slave.
    always_comb begin
        sel_resp = '0;
        for (int k = 0; k < NS; k++) begin
            if (slv_sel[k]) begin
                sel_resp = sel_resp | slv_resp[k*2 +: 2];
            end
        end
    end

    // Purpose: turn access outcome into slot update, hold and completion.
    always_comb begin
        upd_vld  = act_vld;
        upd_idx  = act_idx;
        upd_stat = ST_BUSY;
        upd_step = 1'b0;
        keep     = 1'b0;
        fin      = 1'b0;
        if (act_vld) begin
            if (!go) begin
                upd_stat = ST_FAIL;
                fin      = 1'b1;
            end else begin
                unique case (sel_resp)
                    ST_OK: begin
                        upd_step = 1'b1;
                        if (nxt_addr > act_end) begin
                            upd_stat = ST_OK;
                            fin      = 1'b1;
                        end
                    end
                    ST_FAIL: begin
                        upd_stat = ST_FAIL;
                        fin      = 1'b1;
                    end
                    default: keep = 1'b1;
                endcase
            end
        end
    end

    assign grant_vld = pick_ok && !cur_vld && arb_pick_lock;
    assign grant_idx = act_idx;
    assign clr_locks = !keep;
    assign slv_owner = act_idx;
    assign done      = done_q;

    // Purpose: hold the current request across slave wait replies and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vld <= 1'b0;
            cur_idx <= '0;
            done_q  <= '0;
        end else begin
            cur_vld <= keep;
            cur_idx <= act_idx;
            done_q  <= '0;
            if (fin && (int'(act_idx) < NM)) begin
                done_q[act_idx] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/burst_xfer_ctrl.sv
// Top of the burst bus transfer controller.
// Wires the slot bank, the engine and the range decoder together.
// Assumes an external combinational arbiter and same-cycle slave replies.
module burst_xfer_ctrl
    import bxc_pkg::*;
#(
    parameter int NM = 3,
    parameter int NS = 2,
    parameter int AW = 16,
    parameter int CW = 4,
    parameter logic [NS*AW-1:0] SLV_LO = {16'h0080, 16'h0000},
    parameter logic [NS*AW-1:0] SLV_HI = {16'h00FF, 16'h007F},
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NM-1:0]     iss_vld,
    input  logic [NM-1:0]     iss_write,
    input  logic [NM-1:0]     iss_lock,
    input  logic [NM*AW-1:0]  iss_addr,
    input  logic [NM*CW-1:0]  iss_cnt,
    output logic [NM-1:0]     iss_err,
    output logic [NM*2-1:0]   xfer_stat,
    output logic [NM-1:0]     xfer_done,
    output logic [NM-1:0]     arb_offer,
    output logic [NM*2-1:0]   arb_lock,
    input  logic              arb_pick_vld,
    input  logic [IW-1:0]     arb_pick_idx,
    input  logic              arb_pick_lock,
    output logic [NS-1:0]     slv_sel,
    output logic              slv_write,
    output logic [AW-1:0]     slv_addr,
    output logic [IW-1:0]     slv_owner,
    input  logic [NS*2-1:0]   slv_resp
);

    logic [NM*AW-1:0]      addr_flat;
    logic [NM*(AW+1)-1:0]  end_flat;
    logic [NM-1:0]         wr_vec;
    logic                  upd_vld;
    logic [IW-1:0]         upd_idx;
    logic [1:0]            upd_stat;
    logic                  upd_step;
    logic                  grant_vld;
    logic [IW-1:0]         grant_idx;
    logic                  clr_locks;
    logic [NS-1:0]         dec_hit;
    logic                  dec_any;
    logic [AW-1:0]         act_addr;

    bxc_slot_bank #(.NM(NM), .AW(AW), .CW(CW), .IW(IW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_vld   (iss_vld),
        .iss_write (iss_write),
        .iss_lock  (iss_lock),
        .iss_addr  (iss_addr),
        .iss_cnt   (iss_cnt),
        .upd_vld   (upd_vld),
        .upd_idx   (upd_idx),
        .upd_stat  (upd_stat),
        .upd_step  (upd_step),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx),
        .clr_locks (clr_locks),
        .stat_flat (xfer_stat),
        .lock_flat (arb_lock),
        .addr_flat (addr_flat),
        .end_flat  (end_flat),
        .wr_vec    (wr_vec),
        .iss_err   (iss_err)
    );

    bxc_range_decode #(.NS(NS), .AW(AW), .LO(SLV_LO), .HI(SLV_HI)) u_dec (
        .addr (act_addr),
        .hit  (dec_hit),
        .any  (dec_any)
    );

    bxc_engine #(.NM(NM), .NS(NS), .AW(AW), .IW(IW)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_flat     (xfer_stat),
        .addr_flat     (addr_flat),
        .end_flat      (end_flat),
        .wr_vec        (wr_vec),
        .arb_pick_vld  (arb_pick_vld),
        .arb_pick_idx  (arb_pick_idx),
        .arb_pick_lock (arb_pick_lock),
        .dec_hit       (dec_hit),
        .dec_any       (dec_any),
        .slv_resp      (slv_resp),
        .arb_offer     (arb_offer),
        .act_addr      (act_addr),
        .slv_sel       (slv_sel),
        .slv_write     (slv_write),
        .slv_owner     (slv_owner),
        .upd_vld       (upd_vld),
        .upd_idx       (upd_idx),
        .upd_stat      (upd_stat),
        .upd_step      (upd_step),
        .grant_vld     (grant_vld),
        .grant_idx     (grant_idx),
        .clr_locks     (clr_locks),
        .done          (xfer_done)
    );

    assign slv_addr = act_addr;

endmodule

// File: rtl/burst_xfer_ctrl_chk.sv
// Port-level protocol checker for burst_xfer_ctrl, attached with bind.
module burst_xfer_ctrl_chk #(
    parameter int NM = 3,
    parameter int NS = 2,
    parameter int AW = 16,
    parameter int IW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NM-1:0]     iss_vld,
    input logic [NM-1:0]     iss_err,
    input logic [NM*2-1:0]   xfer_stat,
    input logic [NM-1:0]     xfer_done,
    input logic [NM-1:0]     arb_offer,
    input logic [NS-1:0]     slv_sel,
    input logic [AW-1:0]     slv_addr,
    input logic [IW-1:0]     slv_owner,
    input logic [NS*2-1:0]   slv_resp
);

    logic [1:0] sel_resp;
    logic       held;

    // Purpose: reply of whichever slave is selected.
    always_comb begin
        sel_resp = 2'd0;
        for (int k = 0; k < NS; k++) begin
            if (slv_sel[k]) sel_resp = sel_resp | slv_resp[k*2 +: 2];
        end
        held = (|slv_sel) && (sel_resp != 2'd2) && (sel_resp != 2'd3);
    end

    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slv_sel));

    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|slv_sel) |-> (slv_addr[1:0] == 2'b00));

    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ((slv_owner == $past(slv_owner)) && (slv_addr == $past(slv_addr))
                  && (arb_offer == '0) && (slv_sel == $past(slv_sel))));

    for (genvar g = 0; g < NM; g++) begin : g_m
        p_done_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_done[g] |-> (xfer_stat[g*2 +: 2] >= 2'd2));

        p_offer_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
            arb_offer[g] |-> (xfer_stat[g*2 +: 2] <= 2'd1));

        p_bad_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_vld[g] && (xfer_stat[g*2 +: 2] <= 2'd1)) |=> iss_err[g]);
    end

endmodule

bind burst_xfer_ctrl burst_xfer_ctrl_chk #(.NM(NM), .NS(NS), .AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_vld   (iss_vld),
    .iss_err   (iss_err),
    .xfer_stat (xfer_stat),
    .xfer_done (xfer_done),
    .arb_offer (arb_offer),
    .slv_sel   (slv_sel),
    .slv_addr  (slv_addr),
    .slv_owner (slv_owner),
    .slv_resp  (slv_resp)
);

// File: tb/burst_xfer_ctrl_bench.sv
// Directed bench for burst_xfer_ctrl: a fixed-priority arbiter model,
// a zero-wait slave 0 with error injection and a wait-state slave 1.
module burst_xfer_ctrl_bench;

    localparam int NM = 3;
    localparam int NS = 2;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NM-1:0]     iss_vld = '0;
    logic [NM-1:0]     iss_write = '0;
    logic [NM-1:0]     iss_lock = '0;
    logic [NM*AW-1:0]  iss_addr = '0;
    logic [NM*CW-1:0]  iss_cnt = '0;
    logic [NM-1:0]     iss_err;
    logic [NM*2-1:0]   xfer_stat;
    logic [NM-1:0]     xfer_done;
    logic [NM-1:0]     arb_offer;
    logic [NM*2-1:0]   arb_lock;
    logic              arb_pick_vld;
    logic [IW-1:0]     arb_pick_idx;
    logic              arb_pick_lock;
    logic [NS-1:0]     slv_sel;
    logic              slv_write;
    logic [AW-1:0]     slv_addr;
    logic [IW-1:0]     slv_owner;
    logic [NS*2-1:0]   slv_resp;

    int n_chk = 0;
    int n_bad = 0;
    int w1 = 0;
    int s1_cnt = 0;
    logic s0_err = 1'b0;

    always #4 clk = ~clk;

    burst_xfer_ctrl #(.NM(NM), .NS(NS), .AW(AW), .CW(CW)) u_burst_xfer_ctrl (.*);

    // Arbiter model: lowest offered index wins, always asks for lock grant.
    always_comb begin
        arb_pick_vld  = 1'b0;
        arb_pick_idx  = '0;
        arb_pick_lock = 1'b1;
        for (int i = NM - 1; i >= 0; i--) begin
            if (arb_offer[i]) begin
                arb_pick_vld = 1'b1;
                arb_pick_idx = IW'(i);
            end
        end
    end

    // Slave models.
    always_comb begin
        slv_resp[1:0] = s0_err ? 2'd3 : 2'd2;
        slv_resp[3:2] = (s1_cnt >= w1) ? 2'd2 : 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_cnt <= 0;
        else if (slv_sel[1]) s1_cnt <= (slv_resp[3:2] == 2'd2) ? 0 : s1_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int st(input int m);
        return int'(xfer_stat[m*2 +: 2]);
    endfunction

    function automatic int lk(input int m);
        return int'(arb_lock[m*2 +: 2]);
    endfunction

    // Drive one issue at a falling edge; returns at the next falling edge.
    task automatic issue(input int m, input logic wr, input logic lck,
                         input int addr, input int cnt);
        iss_vld[m]            = 1'b1;
        iss_write[m]          = wr;
        iss_lock[m]           = lck;
        iss_addr[m*AW +: AW]  = AW'(addr);
        iss_cnt[m*CW +: CW]   = CW'(cnt);
        @(negedge clk);
        iss_vld[m]  = 1'b0;
        iss_lock[m] = 1'b0;
    endtask

    task automatic t_reset;
        for (int m = 0; m < NM; m++) begin
            chk("R1 status", st(m), 2);
            chk("R1 lock", lk(m), 0);
        end
        chk("R1 select", int'(slv_sel), 0);
        chk("R1 done", int'(xfer_done), 0);
        chk("R1 issue error", int'(iss_err), 0);
    endtask

    task automatic t_single;
        issue(0, 1'b0, 1'b0, 'h10, 0);
        chk("R2 queued", st(0), 0);
        chk("R10 offer", int'(arb_offer), 1);
        chk("R5 select", int'(slv_sel), 1);
        chk("R5 address", int'(slv_addr), 'h10);
        chk("R5 write", int'(slv_write), 0);
        @(negedge clk);
        chk("R6 status ok", st(0), 2);
        chk("R6 done", int'(xfer_done), 1);
        @(negedge clk);
        chk("R6 done pulse ends", int'(xfer_done), 0);
    endtask

    task automatic t_burst;
        issue(2, 1'b1, 1'b0, 'h20, 3);
        for (int k = 0; k < 4; k++) begin
            chk("R6 word address", int'(slv_addr), 'h20 + 4 * k);
            chk("R6 owner", int'(slv_owner), 2);
            chk("R6 write", int'(slv_write), 1);
            @(negedge clk);
            if (k < 3) begin
                chk("R6 mid-burst status", st(2), 1);
                chk("R6 no early done", int'(xfer_done), 0);
            end
        end
        chk("R6 burst done", int'(xfer_done), 4);
        chk("R6 burst ok", st(2), 2);
    endtask

    task automatic t_bad_addr(input int addr, input string req);
        issue(1, 1'b0, 1'b0, addr, 0);
        chk(req, int'(slv_sel), 0);
        @(negedge clk);
        chk(req, st(1), 3);
        chk(req, int'(xfer_done), 2);
    endtask

    task automatic t_slow;
        w1 = 2;
        issue(0, 1'b0, 1'b0, 'h84, 0);
        chk("R5 second range", int'(slv_sel), 2);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R8 held status", st(0), 1);
            chk("R8 no offer", int'(arb_offer), 0);
            chk("R8 same address", int'(slv_addr), 'h84);
            chk("R8 same slave", int'(slv_sel), 2);
        end
        @(negedge clk);
        chk("R8 done after waits", int'(xfer_done), 1);
        chk("R8 ok", st(0), 2);
    endtask

    task automatic t_slave_err;
        s0_err = 1'b1;
        issue(1, 1'b1, 1'b0, 'h40, 2);
        @(negedge clk);
        s0_err = 1'b0;
        chk("R9 error status", st(1), 3);
        chk("R9 done", int'(xfer_done), 2);
    endtask

    task automatic t_interleave;
        issue(1, 1'b0, 1'b0, 'h00, 2);
        chk("R7 first word owner", int'(slv_owner), 1);
        issue(0, 1'b1, 1'b0, 'h70, 0);
        chk("R10 both offered", int'(arb_offer), 3);
        chk("R7 cut-in owner", int'(slv_owner), 0);
        chk("R7 cut-in address", int'(slv_addr), 'h70);
        @(negedge clk);
        chk("R7 cut-in done", int'(xfer_done), 1);
        chk("R7 resume owner", int'(slv_owner), 1);
        chk("R7 resume address", int'(slv_addr), 'h04);
        @(negedge clk);
        chk("R7 last address", int'(slv_addr), 'h08);
        @(negedge clk);
        chk("R7 burst done", int'(xfer_done), 2);
        chk("R7 interrupted burst ok", st(1), 2);
    endtask

    task automatic t_reissue;
        w1 = 4;
        issue(2, 1'b0, 1'b0, 'h88, 0);
        issue(2, 1'b1, 1'b0, 'h00, 0);
        chk("R12 error pulse", int'(iss_err), 4);
        chk("R12 address kept", int'(slv_addr), 'h88);
        chk("R12 direction kept", int'(slv_write), 0);
        while (xfer_done[2] == 1'b0) @(negedge clk);
        chk("R12 original ok", st(2), 2);
        @(negedge clk);
        chk("R12 error pulse ends", int'(iss_err), 0);
        chk("R12 no stray access", int'(slv_sel), 0);
    endtask

    task automatic t_lock;
        w1 = 2;
        issue(0, 1'b0, 1'b1, 'h80, 0);
        chk("R11 held on issue", lk(0), 1);
        @(negedge clk);
        chk("R11 granted while held", lk(0), 2);
        @(negedge clk);
        @(negedge clk);
        chk("R11 done", int'(xfer_done), 1);
        chk("R11 relaxed to held", lk(0), 1);
        issue(0, 1'b0, 1'b1, 'h04, 0);
        chk("R11 issue beats clear", lk(0), 2);
        @(negedge clk);
        chk("R11 second done", int'(xfer_done), 1);
        chk("R11 held after finish", lk(0), 1);
        @(negedge clk);
        chk("R11 idle clears", lk(0), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_bad_addr('h12, "R3 misaligned");
        t_bad_addr('h200, "R4 unmapped");
        t_slow();
        t_slave_err();
        @(negedge clk);
        t_interleave();
        @(negedge clk);
        t_reissue();
        @(negedge clk);
        t_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule